// File: doc/BRIEF.md
# UART Interrupt Identification and Priority

This block sits beside one serial channel and decides which of its interrupt conditions software hears about first. It keeps a pending flag for each event-type source: line errors, receive timeout, transmitter holding register empty and modem input change. Receive data available arrives as a level from the FIFO logic and is used as it stands. An enable per source masks each flag. The block ranks the enabled conditions and keeps an identification byte that the CPU reads to find the service routine. An active-high interrupt line shows whether any enabled condition is pending.

The CPU read strobe for the identification byte may last several cycles. For that whole access the byte stays frozen. Events that arrive during the access are still recorded and show up once the strobe drops. Each source has its own clear action: a read of the line status register, the receive buffer or the modem status register, or a write to the transmit holding register. The transmit-empty flag also clears when an identification read begins while transmit-empty is the cause on display.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0x01 and the interrupt line is 0.
- R2: Enabled sources are ranked from highest to lowest as: line status, then data available, then receive timeout (both on the second level, with data available ahead), then transmit empty, then modem status. Only the highest one is shown.
- R3: Bits 3:1 show the cause as 011 for line status, 010 for data available, 110 for receive timeout, 001 for transmit empty and 000 for modem status. Bit 0 is 0 while a cause is shown and 1 when none is pending, with bits 3:1 then at 000.
- R4: Bits 7:6 are 11 when the FIFO-enable input is 1 and 00 when it is 0. Bits 5:4 are always 0. While FIFO mode is off, a timeout event is not recorded, so bit 3 reads 0.
- R5: While the identification read strobe is high, the byte holds the value it had when the strobe rose. Events during the read are recorded and appear on the first cycle after the strobe falls.
- R6: A line status register read clears the line status cause. A modem status register read clears the modem status cause.
- R7: A write to the transmit holding register clears the transmit-empty cause. The first cycle of an identification read also clears it when the byte on display at that moment has bits 3:0 equal to 0010.
- R8: An identification read that begins while another cause is on display leaves a pending transmit-empty cause in place.
- R9: A source with its enable at 0 is neither shown nor counted. The data-available enable governs both data available and receive timeout.
- R10: The interrupt line is 1 exactly when at least one enabled cause is pending. It does not freeze during a read.
- R11: A transmit-empty event sets the cause again after any clear. On every event-type source, an event wins over a clear in the same cycle.
- R12: A receive buffer read clears the receive timeout cause.
- R13: Data available follows its level input: it is shown while the level is 1 and drops once the level returns to 0.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO mode enabled |
| en_rls | input | 1 | Line status interrupt enable |
| en_rda | input | 1 | Data available and timeout enable |
| en_thre | input | 1 | Transmit-empty enable |
| en_msr | input | 1 | Modem status enable |
| lsr_evt | input | 1 | Line error event pulse |
| rda_lvl | input | 1 | Receive data at or above threshold (level) |
| cto_evt | input | 1 | Receive timeout event pulse |
| thre_evt | input | 1 | Transmit holding register became empty, pulse |
| msr_evt | input | 1 | Modem input change event pulse |
| iir_rd | input | 1 | Identification read strobe, high for the whole access |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
On every cycle the assertions check the following. The byte stays put during a read. An idle byte has bits 3:1 at zero. The interrupt line agrees with bit 0 of the next unfrozen byte. Each clear strobe, when not overridden by an event, drops its flag. An enabled line-status cause always wins the byte. Only the bench scenarios can show the complete ranking across combinations of enables and the FIFO mode. They also cover the deferred update after a frozen read, the clear-on-identification-read that applies only when transmit-empty is on display, and the re-arming of transmit-empty.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ID_W   = 8;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CAUSE_MSR  = 3'b000,
        CAUSE_THRE = 3'b001,
        CAUSE_RDA  = 3'b010,
        CAUSE_RLS  = 3'b011,
        CAUSE_CTO  = 3'b110
    } cause_e;

    // latched event-type sources
    typedef struct packed {
        logic rls;
        logic cto;
        logic thre;
        logic msr;
    } latch_t;

    // all sources as seen by the ranking logic
    typedef struct packed {
        logic rls;
        logic rda;
        logic cto;
        logic thre;
        logic msr;
    } pend_t;

    localparam logic [3:0] THRE_NIBBLE = {CAUSE_THRE, 1'b0};

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fifo_en,
    input  logic  lsr_evt,
    input  logic  rda_lvl,
    input  logic  cto_evt,
    input  logic  thre_evt,
    input  logic  msr_evt,
    input  logic  lsr_rd,
    input  logic  rbr_rd,
    input  logic  msr_rd,
    input  logic  thr_wr,
    input  logic  thre_ack,
    output pend_t pend
);

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clears first, events override
        if (lsr_rd)              st_d.rls  = 1'b0;
        if (lsr_evt)             st_d.rls  = 1'b1;
        if (rbr_rd || !fifo_en)  st_d.cto  = 1'b0;
        if (cto_evt && fifo_en)  st_d.cto  = 1'b1;
        if (thr_wr || thre_ack)  st_d.thre = 1'b0;
        if (thre_evt)            st_d.thre = 1'b1;
        if (msr_rd)              st_d.msr  = 1'b0;
        if (msr_evt)             st_d.msr  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pend.rls  = st_q.rls;
        pend.rda  = rda_lvl;
        pend.cto  = st_q.cto;
        pend.thre = st_q.thre;
        pend.msr  = st_q.msr;
    end

    assert_lsr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !lsr_evt) |=> !pend.rls);

    assert_msr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !msr_evt) |=> !pend.msr);

    assert_thre_wr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thre_evt) |=> !pend.thre);

    assert_thre_rearm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        thre_evt |=> pend.thre);

    assert_cto_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_rd && !cto_evt) |=> !pend.cto);

endmodule

// File: rtl/uart_irq_rank.sv
module uart_irq_rank
    import uart_irq_pkg::*;
(
    input  pend_t  pend,
    input  logic   fifo_en,
    input  logic   en_rls,
    input  logic   en_rda,
    input  logic   en_thre,
    input  logic   en_msr,
    output logic   any,
    output cause_e cause
);

    pend_t act;

    always_comb begin
        act.rls  = pend.rls  & en_rls;
        act.rda  = pend.rda  & en_rda;
        act.cto  = pend.cto  & en_rda & fifo_en;
        act.thre = pend.thre & en_thre;
        act.msr  = pend.msr  & en_msr;
        any      = |act;
    end

    always_comb begin
        if (act.rls)       cause = CAUSE_RLS;
        else if (act.rda)  cause = CAUSE_RDA;
        else if (act.cto)  cause = CAUSE_CTO;
        else if (act.thre) cause = CAUSE_THRE;
        else               cause = CAUSE_MSR;
    end

endmodule

// File: rtl/uart_irq_view.sv
module uart_irq_view
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iir_rd,
    input  logic            fifo_en,
    input  logic            any,
    input  cause_e          cause,
    output logic [ID_W-1:0] iir_q,
    output logic            thre_ack
);

    typedef struct packed {
        logic [ID_W-1:0] iir;
        logic            rd;
    } view_t;

    view_t           st_d, st_q;
    logic [ID_W-1:0] live;

    always_comb begin
        live = {fifo_en, fifo_en, 2'b00,
                cause[2] & fifo_en, cause[1:0], ~any};
        st_d    = st_q;
        st_d.rd = iir_rd;
        if (!iir_rd) st_d.iir = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {8'h01, 1'b0};
        else        st_q <= st_d;
    end

    assign iir_q    = st_q.iir;
    assign thre_ack = iir_rd & ~st_q.rd & (st_q.iir[3:0] == THRE_NIBBLE);

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rd |=> $stable(iir_q));

    assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iir_q[0] |-> (iir_q[3:1] == 3'b000));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       en_rls,
    input  logic       en_rda,
    input  logic       en_thre,
    input  logic       en_msr,
    input  logic       lsr_evt,
    input  logic       rda_lvl,
    input  logic       cto_evt,
    input  logic       thre_evt,
    input  logic       msr_evt,
    input  logic       iir_rd,
    input  logic       lsr_rd,
    input  logic       rbr_rd,
    input  logic       msr_rd,
    input  logic       thr_wr,
    output logic [7:0] iir_q,
    output logic       irq
);

    pend_t  pend;
    logic   any;
    cause_e cause;
    logic   thre_ack;

    uart_irq_src u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .lsr_evt  (lsr_evt),
        .rda_lvl  (rda_lvl),
        .cto_evt  (cto_evt),
        .thre_evt (thre_evt),
        .msr_evt  (msr_evt),
        .lsr_rd   (lsr_rd),
        .rbr_rd   (rbr_rd),
        .msr_rd   (msr_rd),
        .thr_wr   (thr_wr),
        .thre_ack (thre_ack),
        .pend     (pend)
    );

    uart_irq_rank u_rank (
        .pend    (pend),
        .fifo_en (fifo_en),
        .en_rls  (en_rls),
        .en_rda  (en_rda),
        .en_thre (en_thre),
        .en_msr  (en_msr),
        .any     (any),
        .cause   (cause)
    );

    uart_irq_view u_view (
        .clk      (clk),
        .rst_n    (rst_n),
        .iir_rd   (iir_rd),
        .fifo_en  (fifo_en),
        .any      (any),
        .cause    (cause),
        .iir_q    (iir_q),
        .thre_ack (thre_ack)
    );

    assign irq = any;

    assert_irq_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !iir_rd) |=> iir_q[0]);

    assert_irq_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !iir_rd) |=> !iir_q[0]);

    assert_rls_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.rls && en_rls && !iir_rd) |=> (iir_q[3:0] == 4'b0110));

    assert_rda_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rda |-> (cause != CAUSE_RDA && cause != CAUSE_CTO));

endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 14;

    // [18:15] enables rls,rda,thre,msr  [14] fifo  [13:9] events rls,rda,cto,thre,msr
    // [8] expected irq  [7:0] expected identification byte
    localparam logic [18:0] VEC [NVEC] = '{
        {4'b1111, 1'b1, 5'b11111, 1'b1, 8'hC6},
        {4'b1111, 1'b1, 5'b01111, 1'b1, 8'hC4},
        {4'b1111, 1'b1, 5'b00111, 1'b1, 8'hCC},
        {4'b1111, 1'b1, 5'b00011, 1'b1, 8'hC2},
        {4'b1111, 1'b1, 5'b00001, 1'b1, 8'hC0},
        {4'b1111, 1'b1, 5'b00000, 1'b0, 8'hC1},
        {4'b1111, 1'b0, 5'b00100, 1'b0, 8'h01},
        {4'b1111, 1'b0, 5'b01000, 1'b1, 8'h04},
        {4'b1111, 1'b0, 5'b10000, 1'b1, 8'h06},
        {4'b0111, 1'b1, 5'b10001, 1'b1, 8'hC0},
        {4'b1011, 1'b1, 5'b01110, 1'b1, 8'hC2},
        {4'b1101, 1'b1, 5'b00010, 1'b0, 8'hC1},
        {4'b1110, 1'b0, 5'b00001, 1'b0, 8'h01},
        {4'b0000, 1'b1, 5'b11111, 1'b0, 8'hC1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       en_rls = 1'b0, en_rda = 1'b0, en_thre = 1'b0, en_msr = 1'b0;
    logic       lsr_evt = 1'b0, rda_lvl = 1'b0, cto_evt = 1'b0, thre_evt = 1'b0, msr_evt = 1'b0;
    logic       iir_rd = 1'b0, lsr_rd = 1'b0, rbr_rd = 1'b0, msr_rd = 1'b0, thr_wr = 1'b0;
    logic [7:0] iir_q;
    logic       irq;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident dut (
        .clk (clk), .rst_n (rst_n), .fifo_en (fifo_en),
        .en_rls (en_rls), .en_rda (en_rda), .en_thre (en_thre), .en_msr (en_msr),
        .lsr_evt (lsr_evt), .rda_lvl (rda_lvl), .cto_evt (cto_evt),
        .thre_evt (thre_evt), .msr_evt (msr_evt),
        .iir_rd (iir_rd), .lsr_rd (lsr_rd), .rbr_rd (rbr_rd),
        .msr_rd (msr_rd), .thr_wr (thr_wr),
        .iir_q (iir_q), .irq (irq)
    );

    task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got irq=%0b id=%02h, expected irq=%0b id=%02h",
                     tag, got[8], got[7:0], exp[8], exp[7:0]);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic clear_strobes();
        lsr_evt = 0; cto_evt = 0; thre_evt = 0; msr_evt = 0;
        lsr_rd = 0; rbr_rd = 0; msr_rd = 0; thr_wr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_strobes();
        rda_lvl = 0; iir_rd = 0;
        rst_n = 0;
        tick(1);
        rst_n = 1;
        tick(1);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 reset", {irq, iir_q}, {1'b0, 8'h01});

        // table: R2 R3 R4 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            {en_rls, en_rda, en_thre, en_msr} = VEC[v][18:15];
            fifo_en = VEC[v][14];
            {lsr_evt, rda_lvl, cto_evt, thre_evt, msr_evt} = VEC[v][13:9];
            tick(1);
            clear_strobes();
            tick(1);
            chk($sformatf("R2/R3/R4/R9/R10 vector %0d", v), {irq, iir_q}, VEC[v][8:0]);
            rda_lvl = 0;
        end

        // R5: freeze during read, deferred update
        do_reset();
        {en_rls, en_rda, en_thre, en_msr} = 4'b1111;
        fifo_en = 1;
        msr_evt = 1; tick(1); clear_strobes(); tick(1);
        chk("R5 before read", {irq, iir_q}, {1'b1, 8'hC0});
        iir_rd = 1; tick(1);
        lsr_evt = 1; tick(1); clear_strobes(); tick(2);
        chk("R5 frozen during read", {irq, iir_q}, {1'b1, 8'hC0});
        iir_rd = 0; tick(1);
        chk("R5 update after read", {irq, iir_q}, {1'b1, 8'hC6});

        // R6: status reads clear their causes
        lsr_rd = 1; tick(1); clear_strobes(); tick(1);
        chk("R6 line status cleared", {irq, iir_q}, {1'b1, 8'hC0});
        msr_rd = 1; tick(1); clear_strobes(); tick(1);
        chk("R6 modem status cleared", {irq, iir_q}, {1'b0, 8'hC1});

        // R7: write clears transmit-empty
        thre_evt = 1; tick(1); clear_strobes(); tick(1);
        chk("R7 transmit empty shown", {irq, iir_q}, {1'b1, 8'hC2});
        thr_wr = 1; tick(1); clear_strobes(); tick(1);
        chk("R7 cleared by write", {irq, iir_q}, {1'b0, 8'hC1});

        // R7: identification read clears it when displayed
        thre_evt = 1; tick(1); clear_strobes(); tick(1);
        iir_rd = 1; tick(2);
        chk("R7 frozen while read clears source", {irq, iir_q}, {1'b0, 8'hC2});
        iir_rd = 0; tick(1);
        chk("R7 cleared by identification read", {irq, iir_q}, {1'b0, 8'hC1});

        // R11: re-arm after clear
        thre_evt = 1; tick(1); clear_strobes(); tick(1);
        chk("R11 re-armed", {irq, iir_q}, {1'b1, 8'hC2});
        // R11: event wins over same-cycle write
        thr_wr = 1; thre_evt = 1; tick(1); clear_strobes(); tick(1);
        chk("R11 event beats clear", {irq, iir_q}, {1'b1, 8'hC2});

        // R8: read while line status displayed keeps transmit-empty
        lsr_evt = 1; tick(1); clear_strobes(); tick(1);
        chk("R8 line status over transmit empty", {irq, iir_q}, {1'b1, 8'hC6});
        iir_rd = 1; tick(1); iir_rd = 0; tick(1);
        lsr_rd = 1; tick(1); clear_strobes(); tick(1);
        chk("R8 transmit empty survives", {irq, iir_q}, {1'b1, 8'hC2});
        thr_wr = 1; tick(1); clear_strobes(); tick(1);

        // R12: timeout cleared by receive buffer read
        cto_evt = 1; tick(1); clear_strobes(); tick(1);
        chk("R12 timeout shown", {irq, iir_q}, {1'b1, 8'hCC});
        rbr_rd = 1; tick(1); clear_strobes(); tick(1);
        chk("R12 timeout cleared", {irq, iir_q}, {1'b0, 8'hC1});

        // R13: data available follows level
        rda_lvl = 1; tick(1);
        chk("R13 level high", {irq, iir_q}, {1'b1, 8'hC4});
        rda_lvl = 0; tick(1);
        chk("R13 level low", {irq, iir_q}, {1'b0, 8'hC1});

        // R4: leaving FIFO mode drops upper bits
        fifo_en = 0; tick(1);
        chk("R4 non-FIFO idle", {irq, iir_q}, {1'b0, 8'h01});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule